// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block sits beside a five-stage in-order pipeline. It decides which exception is taken and makes that exception precise. Two sources can raise an exception. The decode stage reports an undefined opcode, and the execute stage reports an arithmetic overflow. Each source comes with the PC of the instruction that raised it. When several sources fire in the same cycle, the block picks the one from the instruction that is furthest along the pipeline. It then does four things in that same cycle:

- It raises nullify controls for the stage that faulted and for every younger stage. The pipeline clears the register-write, memory-write, branch and jump controls of those instructions, so they flow on as bubbles.
- It presents the handler address to the PC mux, with priority over a branch redirect.
- It loads the exception PC register with the faulting PC on the next clock edge.
- It loads the one-bit cause register on that same edge.

The handler address is either one fixed entry point or a per-cause vector, selected by an input. The block assumes the pipeline advances one stage every cycle. Under that assumption it remembers which instructions it, or an older branch flush, has just turned into bubbles. When those instructions arrive in decode and execute on the next cycle, any exception flags they raise are ignored.

Top module: `prec_exc_ctrl`

## Requirements
- R1: Reset behaviour. While `rst_ni` is low, `epc_o` is 0 and `cause_o` is 0. After reset, no stage is treated as nullified, so an exception in the first cycle after reset is taken.
- R2: Overflow commit. An execute overflow with `ex_valid_i` high that has not been masked sets `exc_commit_o` in the same cycle. On the following edge `epc_o` becomes `ex_pc_i` and `cause_o` becomes 1.
- R3: Overflow squash. When an execute overflow is committed, `nullify_ex_o`, `nullify_id_o` and `nullify_if_o` are all high in that cycle. This suppresses the faulting instruction's own write and every younger instruction.
- R4: Undefined-opcode commit. A decode undefined-opcode flag with `id_valid_i` high, taken alone, commits. It raises `nullify_id_o` and `nullify_if_o` but leaves `nullify_ex_o` low, so the older instruction completes. On the following edge `epc_o` becomes `id_pc_i` and `cause_o` becomes 0.
- R5: Age priority. When both sources are active in the same cycle, the execute (older) exception is taken.
- R6: Fixed handler. With `vector_mode_i` low, `redirect_pc_o` is 32'h8000_0180 for either cause during a commit.
- R7: Vectored handlers. With `vector_mode_i` high, `redirect_pc_o` during a commit is 32'hC000_0000 for cause 0 (undefined opcode) and 32'hC000_0020 for cause 1 (overflow).
- R8: Redirect priority. An exception commit drives the handler address even when `br_flush_i` is high. A branch flush alone raises `redirect_valid_o` with `redirect_pc_o = br_target_i`, and only `nullify_if_o` among the nullify outputs.
- R9: Register hold. `epc_o` and `cause_o` change only on an edge at the end of a commit cycle.
- R10: Post-commit masking. In the cycle after a commit, the exception flags presented in decode and execute are ignored.
- R11: Post-branch masking. In the cycle after a branch flush, a decode undefined-opcode flag is ignored. An execute overflow in that cycle is still taken.
- R12: Invalid stages. Exception flags are ignored while the valid input of their stage is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vector_mode_i | input | 1 | 1: per-cause vector addresses, 0: single fixed handler |
| id_valid_i | input | 1 | Decode stage holds a real instruction |
| id_undef_i | input | 1 | Decode stage opcode is undefined |
| id_pc_i | input | 32 | PC of the decode-stage instruction |
| ex_valid_i | input | 1 | Execute stage holds a real instruction |
| ex_ovf_i | input | 1 | Execute stage arithmetic overflow |
| ex_pc_i | input | 32 | PC of the execute-stage instruction |
| br_flush_i | input | 1 | Branch resolved taken in decode; fetch must be squashed |
| br_target_i | input | 32 | Branch destination |
| exc_commit_o | output | 1 | An exception is taken this cycle |
| redirect_valid_o | output | 1 | PC mux must load `redirect_pc_o` |
| redirect_pc_o | output | 32 | Handler address or branch target |
| nullify_if_o | output | 1 | Turn the fetch-stage instruction into a bubble |
| nullify_id_o | output | 1 | Turn the decode-stage instruction into a bubble |
| nullify_ex_o | output | 1 | Turn the execute-stage instruction into a bubble |
| epc_o | output | 32 | Exception PC register |
| cause_o | output | 1 | Cause register: 0 undefined opcode, 1 overflow |

## Verification
The bench fires both sources in the same cycle, with a branch flush alongside. A design that ranked by stage order the wrong way would save the decode PC and jump to the undefined-opcode vector. A design that let the branch win the PC mux would send the pipeline to the branch target. In the cycle after a commit and after a branch flush, the bench drives flags from instructions that have already been turned into bubbles. A design without the kill memory would take a second, phantom exception and overwrite the exception PC. It also checks that the faulting execute instruction is itself nullified, and that a decode fault leaves the older execute instruction alone; getting either wrong would corrupt a destination register or drop a completed result. Finally, it drives flags with the stage valid low, and checks reset both at power-up and in the middle of a run.

// File: rtl/prec_exc_pkg.sv
package prec_exc_pkg;
  typedef enum logic {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } exc_cause_e;

  // source index order = age order; highest index is the oldest stage
  localparam int unsigned SRC_ID = 0;
  localparam int unsigned SRC_EX = 1;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/exc_age_arb.sv
module exc_age_arb #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;   // later (older) index overrides
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/exc_kill_track.sv
module exc_kill_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  input  logic br_flush_i,
  output logic kill_id_q_o,
  output logic kill_ex_q_o
);
  // pipeline advances every cycle: what was squashed in IF/ID now sits in ID/EX
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kill_id_q_o <= 1'b0;
      kill_ex_q_o <= 1'b0;
    end else begin
      kill_id_q_o <= commit_i | br_flush_i;
      kill_ex_q_o <= commit_i;
    end
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int unsigned    PC_W          = 32,
  parameter logic [PC_W-1:0] FIXED_HANDLER = 32'h8000_0180,
  parameter logic [PC_W-1:0] VEC_BASE      = 32'hC000_0000,
  parameter int unsigned    VEC_SHIFT     = 5
) (
  input  logic                     vector_mode_i,
  input  prec_exc_pkg::exc_cause_e cause_i,
  output logic [PC_W-1:0]          handler_o
);
  logic [PC_W-1:0] offset;

  always_comb begin
    offset    = PC_W'(cause_i) << VEC_SHIFT;
    handler_o = vector_mode_i ? (VEC_BASE + offset) : FIXED_HANDLER;
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
  parameter int unsigned PC_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     commit_i,
  input  logic [PC_W-1:0]          pc_i,
  input  prec_exc_pkg::exc_cause_e cause_i,
  output logic [PC_W-1:0]          epc_o,
  output logic                     cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o   <= '0;
      cause_o <= 1'b0;
    end else if (commit_i) begin
      epc_o   <= pc_i;
      cause_o <= cause_i;
    end
  end
endmodule

// File: rtl/prec_exc_ctrl.sv
module prec_exc_ctrl
  import prec_exc_pkg::*;
#(
  parameter int unsigned    PC_W          = 32,
  parameter logic [PC_W-1:0] FIXED_HANDLER = 32'h8000_0180,
  parameter logic [PC_W-1:0] VEC_BASE      = 32'hC000_0000,
  parameter int unsigned    VEC_SHIFT     = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vector_mode_i,
  input  logic            id_valid_i,
  input  logic            id_undef_i,
  input  logic [PC_W-1:0] id_pc_i,
  input  logic            ex_valid_i,
  input  logic            ex_ovf_i,
  input  logic [PC_W-1:0] ex_pc_i,
  input  logic            br_flush_i,
  input  logic [PC_W-1:0] br_target_i,
  output logic            exc_commit_o,
  output logic            redirect_valid_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic            nullify_if_o,
  output logic            nullify_id_o,
  output logic            nullify_ex_o,
  output logic [PC_W-1:0] epc_o,
  output logic            cause_o
);
  logic [NUM_SRC-1:0] req, gnt;
  logic               any_req;
  logic               kill_id_q, kill_ex_q;
  exc_cause_e         sel_cause;
  logic [PC_W-1:0]    sel_pc;
  logic [PC_W-1:0]    handler;

  // flags from bubbles created last cycle are dropped
  assign req[SRC_ID] = id_valid_i & id_undef_i & ~kill_id_q;
  assign req[SRC_EX] = ex_valid_i & ex_ovf_i   & ~kill_ex_q;

  exc_age_arb #(.N(NUM_SRC)) u_arb (
    .req_i (req),
    .gnt_o (gnt),
    .any_o (any_req)
  );

  exc_kill_track u_kill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (any_req),
    .br_flush_i  (br_flush_i),
    .kill_id_q_o (kill_id_q),
    .kill_ex_q_o (kill_ex_q)
  );

  always_comb begin
    sel_cause = gnt[SRC_EX] ? CAUSE_OVF : CAUSE_UNDEF;
    sel_pc    = gnt[SRC_EX] ? ex_pc_i   : id_pc_i;
  end

  exc_vector #(
    .PC_W          (PC_W),
    .FIXED_HANDLER (FIXED_HANDLER),
    .VEC_BASE      (VEC_BASE),
    .VEC_SHIFT     (VEC_SHIFT)
  ) u_vec (
    .vector_mode_i (vector_mode_i),
    .cause_i       (sel_cause),
    .handler_o     (handler)
  );

  exc_state_regs #(.PC_W(PC_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (any_req),
    .pc_i     (sel_pc),
    .cause_i  (sel_cause),
    .epc_o    (epc_o),
    .cause_o  (cause_o)
  );

  always_comb begin
    exc_commit_o     = any_req;
    redirect_valid_o = any_req | br_flush_i;
    redirect_pc_o    = any_req ? handler : br_target_i;  // exception beats branch
    nullify_if_o     = any_req | br_flush_i;
    nullify_id_o     = any_req;
    nullify_ex_o     = gnt[SRC_EX];   // faulting EX instr loses its own write
  end
endmodule

// File: rtl/prec_exc_ctrl_chk.sv
module prec_exc_ctrl_chk #(
  parameter int unsigned    PC_W          = 32,
  parameter logic [PC_W-1:0] FIXED_HANDLER = 32'h8000_0180
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            vector_mode_i,
  input logic            id_valid_i,
  input logic            id_undef_i,
  input logic [PC_W-1:0] id_pc_i,
  input logic            ex_valid_i,
  input logic            ex_ovf_i,
  input logic [PC_W-1:0] ex_pc_i,
  input logic            br_flush_i,
  input logic [PC_W-1:0] br_target_i,
  input logic            exc_commit_o,
  input logic            redirect_valid_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic            nullify_if_o,
  input logic            nullify_id_o,
  input logic            nullify_ex_o,
  input logic [PC_W-1:0] epc_o,
  input logic            cause_o
);
  a_r1_reset_regs: assert property (@(posedge clk_i) !rst_ni |-> (epc_o == '0 && !cause_o));

  a_r2_ovf_epc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_commit_o && nullify_ex_o) |=> (epc_o == $past(ex_pc_i) && cause_o));

  a_r3_ovf_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_commit_o && ex_valid_i && ex_ovf_i) |-> (nullify_ex_o && nullify_id_o && nullify_if_o));

  a_r4_undef_epc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_commit_o && !nullify_ex_o) |=> (epc_o == $past(id_pc_i) && !cause_o));

  a_r6_fixed_handler: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_commit_o && !vector_mode_i) |-> (redirect_pc_o == FIXED_HANDLER));

  a_r8_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_commit_o |-> (redirect_valid_o && nullify_if_o));

  a_r8_branch_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_flush_i && !exc_commit_o) |-> (redirect_pc_o == br_target_i && !nullify_id_o && !nullify_ex_o));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_commit_o |=> ($stable(epc_o) && $stable(cause_o)));

  a_r10_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_commit_o |=> !exc_commit_o);

  a_r12_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_valid_i && !ex_valid_i) |-> !exc_commit_o);
endmodule

bind prec_exc_ctrl prec_exc_ctrl_chk #(
  .PC_W          (PC_W),
  .FIXED_HANDLER (FIXED_HANDLER)
) u_chk (.*);

// File: tb/sim_prec_exc_ctrl.sv
`timescale 1ns/1ps
module sim_prec_exc_ctrl;
  typedef struct packed {
    logic        mode;
    logic        idv;
    logic        idu;
    logic [31:0] idpc;
    logic        exv;
    logic        exo;
    logic [31:0] expc;
    logic        br;
    logic [31:0] brt;
    logic        c;
    logic        rv;
    logic [31:0] rpc;
    logic [2:0]  nul;   // {if, id, ex}
    logic [31:0] epc;   // after the edge
    logic        cause; // after the edge
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R1 idle after reset
    '{1'b0,1'b0,1'b0,32'h0,  1'b0,1'b0,32'h0,  1'b0,32'h0,   1'b0,1'b0,32'h0,        3'b000,32'h0,  1'b0},
    // R2 R3 R6 overflow, fixed handler
    '{1'b0,1'b0,1'b0,32'h0,  1'b1,1'b1,32'h100,1'b0,32'h0,   1'b1,1'b1,32'h8000_0180,3'b111,32'h100,1'b1},
    // R10 flags from bubbles ignored
    '{1'b0,1'b1,1'b1,32'h200,1'b1,1'b1,32'h204,1'b0,32'h0,   1'b0,1'b0,32'h0,        3'b000,32'h100,1'b1},
    // R4 R7 undefined opcode, vectored
    '{1'b1,1'b1,1'b1,32'h300,1'b0,1'b0,32'h0,  1'b0,32'h0,   1'b1,1'b1,32'hC000_0000,3'b110,32'h300,1'b0},
    // R9 idle hold
    '{1'b1,1'b0,1'b0,32'h0,  1'b0,1'b0,32'h0,  1'b0,32'h0,   1'b0,1'b0,32'h0,        3'b000,32'h300,1'b0},
    // R5 R7 R8 both sources plus branch
    '{1'b1,1'b1,1'b1,32'h400,1'b1,1'b1,32'h404,1'b1,32'h999, 1'b1,1'b1,32'hC000_0020,3'b111,32'h404,1'b1},
    // R9 idle
    '{1'b0,1'b0,1'b0,32'h0,  1'b0,1'b0,32'h0,  1'b0,32'h0,   1'b0,1'b0,32'h0,        3'b000,32'h404,1'b1},
    // R8 branch only
    '{1'b0,1'b0,1'b0,32'h0,  1'b0,1'b0,32'h0,  1'b1,32'h1234,1'b0,1'b1,32'h1234,     3'b100,32'h404,1'b1},
    // R11 decode masked after branch, execute still taken
    '{1'b0,1'b1,1'b1,32'h500,1'b1,1'b1,32'h504,1'b0,32'h0,   1'b1,1'b1,32'h8000_0180,3'b111,32'h504,1'b1},
    // R9 idle
    '{1'b0,1'b0,1'b0,32'h0,  1'b0,1'b0,32'h0,  1'b0,32'h0,   1'b0,1'b0,32'h0,        3'b000,32'h504,1'b1},
    // R12 flags with valid low
    '{1'b0,1'b0,1'b1,32'h510,1'b0,1'b1,32'h514,1'b0,32'h0,   1'b0,1'b0,32'h0,        3'b000,32'h504,1'b1},
    // R4 R6 undefined opcode, fixed handler
    '{1'b0,1'b1,1'b1,32'h600,1'b0,1'b0,32'h0,  1'b0,32'h0,   1'b1,1'b1,32'h8000_0180,3'b110,32'h600,1'b0},
    // R10 faulting decode instr now in execute is a bubble
    '{1'b0,1'b0,1'b0,32'h0,  1'b1,1'b1,32'h604,1'b0,32'h0,   1'b0,1'b0,32'h0,        3'b000,32'h600,1'b0},
    // R2 R7 overflow, vectored
    '{1'b1,1'b0,1'b0,32'h0,  1'b1,1'b1,32'h700,1'b0,32'h0,   1'b1,1'b1,32'hC000_0020,3'b111,32'h700,1'b1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vector_mode_i = 1'b0;
  logic        id_valid_i = 1'b0, id_undef_i = 1'b0;
  logic [31:0] id_pc_i = '0;
  logic        ex_valid_i = 1'b0, ex_ovf_i = 1'b0;
  logic [31:0] ex_pc_i = '0;
  logic        br_flush_i = 1'b0;
  logic [31:0] br_target_i = '0;
  logic        exc_commit_o, redirect_valid_o;
  logic [31:0] redirect_pc_o;
  logic        nullify_if_o, nullify_id_o, nullify_ex_o;
  logic [31:0] epc_o;
  logic        cause_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  prec_exc_ctrl u0 (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int i);
    case (i)
      0: return "R1";   1: return "R2";   2: return "R10";  3: return "R4";
      4: return "R9";   5: return "R5";   6: return "R9";   7: return "R8";
      8: return "R11";  9: return "R9";   10: return "R12"; 11: return "R4";
      12: return "R10"; default: return "R7";
    endcase
  endfunction

  task automatic drive(input vec_t v);
    vector_mode_i = v.mode;
    id_valid_i = v.idv; id_undef_i = v.idu; id_pc_i = v.idpc;
    ex_valid_i = v.exv; ex_ovf_i = v.exo;   ex_pc_i = v.expc;
    br_flush_i = v.br;  br_target_i = v.brt;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t idle;
    idle = '0;
    repeat (2) @(negedge clk_i);
    // R1 values held in reset
    chk("R1", "epc in reset", epc_o, 32'h0);
    chk("R1", "cause in reset", {31'b0, cause_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i]);
      #1;
      chk(req_of(i), "commit", {31'b0, exc_commit_o}, {31'b0, VECS[i].c});
      chk(req_of(i), "redirect_valid", {31'b0, redirect_valid_o}, {31'b0, VECS[i].rv});
      if (VECS[i].rv) chk(req_of(i), "redirect_pc", redirect_pc_o, VECS[i].rpc);
      chk(req_of(i), "nullify", {29'b0, nullify_if_o, nullify_id_o, nullify_ex_o}, {29'b0, VECS[i].nul});
      @(posedge clk_i);
      #1;
      chk(req_of(i), "epc", epc_o, VECS[i].epc);
      chk(req_of(i), "cause", {31'b0, cause_o}, {31'b0, VECS[i].cause});
    end

    // R1 reset in mid-run clears the registers at once
    @(negedge clk_i);
    drive(idle);
    rst_ni = 1'b0;
    #1;
    chk("R1", "epc async reset", epc_o, 32'h0);
    chk("R1", "cause async reset", {31'b0, cause_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R4 first cycle after reset: decode fault is taken (no stale kill)
    begin
      vec_t v;
      v = '0;
      v.idv = 1'b1; v.idu = 1'b1; v.idpc = 32'h800;
      @(negedge clk_i);
      drive(v);
      #1;
      chk("R1", "commit after reset", {31'b0, exc_commit_o}, 32'h1);
      chk("R6", "fixed handler undef", redirect_pc_o, 32'h8000_0180);
      @(posedge clk_i);
      #1;
      chk("R4", "epc after reset commit", epc_o, 32'h800);
      chk("R4", "cause after reset commit", {31'b0, cause_o}, 32'h0);
    end

    @(negedge clk_i);
    drive(idle);
    @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule